// File: doc/BRIEF.md
# Power-Fail Nibble Autostore Sequencer

This block owns a small volatile register (four bits by default) together with a nonvolatile shadow copy of it. A host reads and writes the register over a parallel port controlled by three active-low strobes, and four output pins always show the register. This lets the register replace a bank of configuration switches whose setting survives power cycles.

The block watches a supply-good input. The input is already resolved with hysteresis: it goes high above the trip level and goes low only about 0.2 V below it. When the supply is lost, the block asserts its reset output at once and raises a serial-abort line, so that new serial reads and writes are blocked and pending commands are dropped. It then copies the register into the shadow copy. If a serial nonvolatile write is still busy, the copy waits until that write has finished. The copy takes a parameterised number of cycles.

When the supply returns, the block loads the shadow copy back into the register. It then holds reset for a power-up timeout, given as a cycle count. Parallel access is allowed only in the run state. If the supply comes back while a store is in progress, the store runs to the end before the recall and the full reset hold.

Top module: `nibble_autostore_seq`

## Requirements
- R1: After a synchronous reset the block is powered off: reset_out=1, serial_abort=1, store_busy=0, dq_oe=0, pins_o=0, and the shadow copy holds SHADOW_INIT (0).
- R2: reset_out and serial_abort are 1 in the same cycle that supply_ok is 0. They stay 1 through the waiting, storing and powered-off phases, whatever supply_ok does in those phases.
- R3: If supply_ok is sampled low in the run state while nv_busy is low, store_busy rises on that edge and stays high for exactly STORE_CYCLES cycles. At the end of the store the shadow copy holds the register value.
- R4: If nv_busy is high when the supply is lost, store_busy stays 0 while nv_busy is sampled high. The store starts on the first edge at which nv_busy is sampled low.
- R5: While powered off the register, and so pins_o, reads 0. One edge after supply_ok is first sampled high, the register and pins_o hold the shadow copy.
- R6: reset_out falls exactly HOLD_CYCLES+2 edges after the first edge at which supply_ok is sampled high, provided that supply_ok stays high throughout.
- R7: A parallel write lasts while ce_n=0 and we_n=0. The value on dq_in in the last cycle of that overlap is stored on the edge at which ce_n or we_n is first sampled high. pins_o shows the new value from that edge on.
- R8: dq_oe=1 exactly when ce_n=0, oe_n=0 and we_n=1 in the run state. While dq_oe=1, dq_out carries the register value.
- R9: Parallel writes outside the run state leave the register unchanged.
- R10: If supply_ok returns during a store, the store still lasts its full STORE_CYCLES cycles. A recall and a full reset hold then follow.
- R11: If supply_ok falls during the reset hold, the block goes straight to powered off with no store (store_busy stays 0), and the register clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Resolved supply-good indication |
| nv_busy | input | 1 | Serial nonvolatile write cycle in progress |
| ce_n | input | 1 | Parallel chip enable, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| we_n | input | 1 | Parallel write enable, active low |
| dq_in | input | DATA_W | Parallel write data |
| dq_out | output | DATA_W | Parallel read data |
| dq_oe | output | 1 | Drive enable for the data pins (low means high impedance) |
| pins_o | output | DATA_W | Continuous mirror of the register |
| reset_out | output | 1 | Reset output, active high |
| serial_abort | output | 1 | Blocks serial activity and drops pending commands |
| store_busy | output | 1 | Nonvolatile store in progress |

## Verification
On every cycle the assertions check the following:
- A store never starts while the serial write is still busy.
- A store, once started, lasts its full length.
- The shadow copy changes only when a store completes.
- A recall copies the shadow into the register.
- The run state is entered only from a completed reset hold.

Whether the right value survives a power cycle is a different matter, and only the bench's scenarios can show it. That covers:
- a write under write-enable control and one under chip-enable control, each reappearing after re-power;
- a store that is held back by a busy serial write;
- a supply that returns in the middle of a store;
- a supply that drops during the reset hold.

// File: rtl/nas_pkg.sv
package nas_pkg;

    typedef enum logic [2:0] {
        POWER_OFF   = 3'd0,
        RECALL      = 3'd1,
        RESET_HOLD  = 3'd2,
        RUN         = 3'd3,
        WAIT_SERIAL = 3'd4,
        STORE       = 3'd5,
        STORED      = 3'd6
    } seq_state_t;

    // Decoded (active-high) parallel strobes
    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } par_ctl_t;

    // Control from the sequencer to the datapath
    typedef struct packed {
        logic clear;
        logic recall;
        logic commit;
        logic allow;
    } seq_ctl_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic in_fail_path(input seq_state_t s);
        return (s == POWER_OFF) || (s == WAIT_SERIAL) || (s == STORE) || (s == STORED);
    endfunction

endpackage

// File: rtl/nas_sequencer.sv
module nas_sequencer
    import nas_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES  = 5_000_000,
    parameter int unsigned STORE_CYCLES = 250_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       nv_busy,
    output seq_state_t state,
    output seq_ctl_t   ctl
);
    localparam int unsigned CNT_MAX = max_u(HOLD_CYCLES, STORE_CYCLES);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] STORE_LAST = CW'(STORE_CYCLES - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            POWER_OFF: if (supply_ok) state_d = RECALL;
            RECALL: begin
                state_d = RESET_HOLD;
                cnt_d   = '0;
            end
            RESET_HOLD: begin
                if (!supply_ok)              state_d = POWER_OFF;
                else if (cnt_q == HOLD_LAST) state_d = RUN;
                else                         cnt_d   = cnt_q + 1'b1;
            end
            RUN: begin
                if (!supply_ok) begin
                    state_d = nv_busy ? WAIT_SERIAL : STORE;
                    cnt_d   = '0;
                end
            end
            WAIT_SERIAL: begin
                if (!nv_busy) begin
                    state_d = STORE;
                    cnt_d   = '0;
                end
            end
            STORE: begin
                if (cnt_q == STORE_LAST) state_d = STORED;
                else                     cnt_d   = cnt_q + 1'b1;
            end
            STORED: state_d = supply_ok ? RECALL : POWER_OFF;
            default: state_d = POWER_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= POWER_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state      = state_q;
    assign ctl.clear  = (state_q == POWER_OFF);
    assign ctl.recall = (state_q == RECALL);
    assign ctl.commit = (state_q == STORE) && (cnt_q == STORE_LAST);
    assign ctl.allow  = (state_q == RUN);

    AST_STORE_AFTER_SERIAL: assert property (@(posedge clk) disable iff (rst)
        (state_q == STORE && $past(state_q) != STORE) |-> !$past(nv_busy)); // R4
    AST_STORE_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (state_q == STORE && cnt_q != STORE_LAST) |=> state_q == STORE); // R10
    AST_RUN_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == RUN && $past(state_q) != RUN) |-> ($past(state_q) == RESET_HOLD && $past(cnt_q) == HOLD_LAST)); // R6
endmodule

// File: rtl/nas_par_port.sv
module nas_par_port
    import nas_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  par_ctl_t          pc,
    input  logic              allow,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_commit,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en
);
    logic              overlap;
    logic              active_q;
    logic [DATA_W-1:0] cap_q;

    assign overlap = pc.sel && pc.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cap_q    <= '0;
        end else begin
            active_q <= overlap && allow;
            if (overlap && allow) cap_q <= dq_in;
        end
    end

    // The write closes when whichever strobe rises first ends the overlap
    assign wr_commit = active_q && !overlap && allow;
    assign wr_data   = cap_q;
    assign rd_en     = allow && pc.sel && pc.rd && !pc.wr;
endmodule

// File: rtl/nas_nibble_store.sv
module nas_nibble_store
    import nas_pkg::*;
#(
    parameter int unsigned       DATA_W      = 4,
    parameter logic [DATA_W-1:0] SHADOW_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] vreg
);
    logic [DATA_W-1:0] vreg_q, shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vreg_q   <= '0;
            shadow_q <= SHADOW_INIT;
        end else begin
            if (ctl.clear)       vreg_q <= '0;
            else if (ctl.recall) vreg_q <= shadow_q;
            else if (wr_commit)  vreg_q <= wr_data;
            if (ctl.commit) shadow_q <= vreg_q;
        end
    end

    assign vreg = vreg_q;

    AST_SHADOW_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        !ctl.commit |=> $stable(shadow_q)); // R3
    AST_RECALL_COPIES_SHADOW: assert property (@(posedge clk) disable iff (rst)
        ctl.recall |=> vreg_q == $past(shadow_q)); // R5
    AST_NO_WRITE_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst)
        (!ctl.allow && !ctl.clear && !ctl.recall) |=> $stable(vreg_q)); // R9
endmodule

// File: rtl/nibble_autostore_seq.sv
module nibble_autostore_seq
    import nas_pkg::*;
#(
    parameter int unsigned       DATA_W       = 4,
    parameter int unsigned       HOLD_CYCLES  = 5_000_000,
    parameter int unsigned       STORE_CYCLES = 250_000,
    parameter logic [DATA_W-1:0] SHADOW_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              nv_busy,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] pins_o,
    output logic              reset_out,
    output logic              serial_abort,
    output logic              store_busy
);
    seq_state_t        state;
    seq_ctl_t          ctl;
    par_ctl_t          pc;
    logic              wr_commit;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] vreg;

    assign pc.sel = !ce_n;
    assign pc.rd  = !oe_n;
    assign pc.wr  = !we_n;

    nas_sequencer #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .STORE_CYCLES(STORE_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .supply_ok(supply_ok),
        .nv_busy  (nv_busy),
        .state    (state),
        .ctl      (ctl)
    );

    nas_par_port #(.DATA_W(DATA_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .pc       (pc),
        .allow    (ctl.allow),
        .dq_in    (dq_in),
        .wr_commit(wr_commit),
        .wr_data  (wr_data),
        .rd_en    (dq_oe)
    );

    nas_nibble_store #(
        .DATA_W     (DATA_W),
        .SHADOW_INIT(SHADOW_INIT)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .wr_commit(wr_commit),
        .wr_data  (wr_data),
        .vreg     (vreg)
    );

    assign dq_out       = vreg;
    assign pins_o       = vreg;
    assign reset_out    = (state != RUN) || !supply_ok;
    assign serial_abort = in_fail_path(state) || !supply_ok;
    assign store_busy   = (state == STORE);

    AST_ABORT_HELD_IN_FAIL: assert property (@(posedge clk) disable iff (rst)
        (store_busy || $fell(store_busy)) |-> (reset_out && serial_abort)); // R2
endmodule

// File: tb/nibble_autostore_seq_bench.sv
`timescale 1ns/1ps
module nibble_autostore_seq_bench;
    localparam int W  = 4;
    localparam int HC = 20;
    localparam int SC = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, nv_busy = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [W-1:0] dq_in = '0;
    logic [W-1:0] dq_out, pins_o;
    logic dq_oe, reset_out, serial_abort, store_busy;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nibble_autostore_seq #(
        .DATA_W(W), .HOLD_CYCLES(HC), .STORE_CYCLES(SC), .SHADOW_INIT(4'h0)
    ) u_nibble_autostore_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .nv_busy(nv_busy),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .pins_o(pins_o),
        .reset_out(reset_out), .serial_abort(serial_abort), .store_busy(store_busy)
    );

    // Behavioural reference: phase 0 off, 1 recall, 2 hold, 3 run, 4 wait, 5 store, 6 stored
    int m_ph = 0;
    int m_cnt = 0;
    logic [W-1:0] m_reg = '0, m_sh = '0, m_cap = '0;
    bit m_act = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_reg = '0; m_sh = '0; m_cap = '0; m_act = 0;
        end else begin
            automatic bit ov = !ce_n && !we_n;
            automatic bit commit = m_act && !ov && (m_ph == 3);
            automatic logic [W-1:0] old_reg = m_reg;
            automatic int nph = m_ph;
            if (m_ph == 0)      m_reg = '0;
            else if (m_ph == 1) m_reg = m_sh;
            else if (commit)    m_reg = m_cap;
            if (ov && m_ph == 3) m_cap = dq_in;
            m_act = ov && (m_ph == 3);
            case (m_ph)
                0: if (supply_ok) nph = 1;
                1: begin nph = 2; m_cnt = 0; end
                2: if (!supply_ok) nph = 0;
                   else if (m_cnt == HC - 1) nph = 3;
                   else m_cnt++;
                3: if (!supply_ok) begin nph = nv_busy ? 4 : 5; m_cnt = 0; end
                4: if (!nv_busy) begin nph = 5; m_cnt = 0; end
                5: if (m_cnt == SC - 1) begin nph = 6; m_sh = old_reg; end
                   else m_cnt++;
                default: nph = supply_ok ? 1 : 0;
            endcase
            m_ph = nph;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            automatic bit e_rst = (m_ph != 3) || !supply_ok;
            automatic bit e_ab  = !supply_ok || m_ph == 0 || m_ph >= 4;
            automatic bit e_oe  = (m_ph == 3) && !ce_n && !oe_n && we_n;
            check(reset_out == e_rst, "R2/R6 reset_out", reset_out, e_rst);
            check(serial_abort == e_ab, "R2 serial_abort", serial_abort, e_ab);
            check(store_busy == (m_ph == 5), "R3 store_busy", store_busy, m_ph == 5);
            check(pins_o == m_reg, "R7 pins_o", pins_o, m_reg);
            check(dq_oe == e_oe, "R8 dq_oe", dq_oe, e_oe);
            if (e_oe) check(dq_out == m_reg, "R8 dq_out", dq_out, m_reg);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic power_up_and_count(input string tag);
        int edges = 0;
        supply_ok = 1'b1;
        while (reset_out && edges < HC + 10) begin step(); edges++; end
        check(edges == HC + 2, tag, edges, HC + 2);
    endtask

    task automatic write_we(input logic [W-1:0] v);
        ce_n = 0; step(); we_n = 0; dq_in = v; step(2); we_n = 1; step(); ce_n = 1; step();
    endtask

    task automatic write_ce(input logic [W-1:0] v);
        we_n = 0; step(); ce_n = 0; dq_in = v; step(2); ce_n = 1; step(); we_n = 1; step();
    endtask

    task automatic count_store(input string tag);
        int len = 0;
        while (!store_busy && len < 50) begin step(); len++; end
        len = 0;
        while (store_busy && len < 50) begin step(); len++; end
        check(len == SC, tag, len, SC);
    endtask

    initial begin
        step(3);
        rst = 0;
        #1;
        // r1_ reset state
        check(reset_out && serial_abort && !store_busy && !dq_oe && pins_o == 0,
              "R1 reset state", {reset_out, serial_abort, store_busy, dq_oe}, 4'b1100);

        power_up_and_count("R6 hold length");
        check(pins_o == 4'h0, "R5 initial recall", pins_o, 0);

        write_we(4'hA);
        check(pins_o == 4'hA, "R7 we-controlled write", pins_o, 4'hA);
        write_ce(4'h5);
        check(pins_o == 4'h5, "R7 ce-controlled write", pins_o, 4'h5);
        ce_n = 0; oe_n = 0; step();
        check(dq_oe && dq_out == 4'h5, "R8 read", dq_out, 4'h5);
        we_n = 0; step();
        check(!dq_oe, "R8 no drive while writing", dq_oe, 0);
        we_n = 1; oe_n = 1; ce_n = 1; step();

        // R3: loss with no serial write
        supply_ok = 0; #1;
        check(reset_out && serial_abort, "R2 immediate on loss", {reset_out, serial_abort}, 2'b11);
        count_store("R3 store length");
        step(2);
        check(pins_o == 0, "R5 cleared while off", pins_o, 0);
        supply_ok = 1; step(2);
        check(pins_o == 4'h5, "R5 recall value", pins_o, 4'h5);
        // R9: write during the reset hold is ignored
        write_we(4'h3);
        check(pins_o == 4'h5, "R9 write ignored in hold", pins_o, 4'h5);
        while (reset_out) step();

        // R4: loss while serial write busy
        write_we(4'hC);
        nv_busy = 1; step(); supply_ok = 0;
        step(8);
        check(!store_busy, "R4 store waits for serial", store_busy, 0);
        nv_busy = 0; step();
        check(store_busy, "R4 store after serial", store_busy, 1);
        step(SC + 3);
        power_up_and_count("R6 hold after repower");
        check(pins_o == 4'hC, "R4 value kept across store", pins_o, 4'hC);

        // R10: supply returns mid-store
        write_ce(4'h9);
        supply_ok = 0; step(3); supply_ok = 1;
        step(); step(SC);
        step(2);
        check(reset_out && pins_o == 4'h9, "R10 recall after completed store", pins_o, 4'h9);
        while (reset_out) step();

        // R11: loss during reset hold
        supply_ok = 0; count_store("R3 store before hold test");
        supply_ok = 1; step(5); supply_ok = 0; step(4);
        check(!store_busy && pins_o == 0, "R11 no store in hold", pins_o, 0);
        step(SC);
        power_up_and_count("R11 hold after aborted hold");
        check(pins_o == 4'h9, "R11 shadow untouched", pins_o, 4'h9);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule